// File: doc/BRIEF.md
# Multi-function 8-bit arithmetic logic unit

This block is a purely combinational arithmetic logic unit for a datapath that works on 8-bit operands. It takes two operands, a carry input and a 5-bit operation code, and returns a 16-bit result together with four status flags: carry, signed overflow, borrow and zero. A wide result lets the full multiply product and a quotient/remainder pair leave the block in one step. Borrow has its own flag, separate from carry.

Inside, the block has three units: an arithmetic unit, a bitwise logic unit and a one-place shift/rotate unit. Each unit decodes its own share of the operation space, and a final multiplexer picks the unit that claimed the code. The operand width is a parameter; 8 is the intended configuration. A generate-time option chooses between a partial-product array multiplier and a plain operator multiplier. The divider is a chain of restoring subtract stages.

Top module: `alu8_core`

## Requirements
- R1: Codes 00000 (A+B) and 00001 (A+B+carry_in) place the 8-bit sum in result[7:0] and zero in result[15:8]; flag_carry is the ninth bit of the sum and flag_borrow is 0.
- R2: Codes 00010 (A−B) and 00011 (A−B−carry_in) form A plus the inverse of B plus one (minus carry_in for 00011). result[7:0] is the wrapped difference, so when A < B it is the two's complement of B−A. flag_borrow is 1 exactly when the unsigned minuend is smaller than the subtrahend, and flag_carry and flag_borrow are never set together.
- R3: flag_overflow is 1 on a signed two's-complement overflow for codes 00000 to 00011. It is 0 for every other code except a divide by zero.
- R4: Code 00100 returns A+1, wrapping 0xFF to 0x00 with flag_carry set. Code 00101 returns A−1, wrapping 0x00 to 0xFF with flag_borrow set.
- R5: Code 00110 returns the full unsigned 16-bit product A×B in result[15:0], with carry, borrow and overflow clear.
- R6: Code 00111 with B ≠ 0 returns the unsigned quotient A/B in result[7:0] and the remainder in result[15:8].
- R7: Code 00111 with B = 0 returns 0xFFFF and sets flag_overflow.
- R8: Codes 01000, 01001, 01010 and 01011 return A AND B, A OR B, A XOR B and NOT A in result[7:0], with result[15:8] zero and carry, borrow and overflow clear.
- R9: Codes 10000 to 10011 move A one place: logical left, logical right, rotate left and rotate right. flag_carry takes the bit that leaves the word (A[7] for the left moves, A[0] for the right moves), and result[15:8] is zero.
- R10: For every valid code, flag_zero is 1 exactly when all 16 result bits are 0.
- R11: Every code not listed in R1 to R9 returns a zero result with all four flags clear, flag_zero included.
- R12: carry_in affects only codes 00001 and 00011. For every other code the outputs do not depend on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_a | input | 8 | First operand; the only source for unary operations |
| operand_b | input | 8 | Second operand |
| carry_in | input | 1 | Carry or borrow input for the two extended arithmetic codes |
| op_sel | input | 5 | Operation code |
| result | output | 16 | Operation result, zero-extended for 8-bit operations |
| flag_carry | output | 1 | Carry out of add/increment, or the bit shifted out |
| flag_overflow | output | 1 | Signed overflow, or divide by zero |
| flag_borrow | output | 1 | Unsigned borrow from subtract/decrement |
| flag_zero | output | 1 | All 16 result bits are zero on a valid code |

## Verification
The embedded assertions check, on every evaluation, the properties that hold across all inputs:
- carry and borrow are never set together;
- an increment carry implies an all-ones operand;
- the array multiplier matches the arithmetic product;
- quotient times divisor plus remainder rebuilds the dividend, with the remainder below the divisor;
- rotates keep the count of ones;
- unused codes stay silent, and at most one unit claims a code.

The exact result values, flag choices per code, wrap-around corners and the independence from carry_in can only be shown by the bench's sweep. That sweep runs every code against every value of A and a set of edge values of B.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ADD = 5'b00000,
      OP_ADC = 5'b00001,
      OP_SUB = 5'b00010,
      OP_SBB = 5'b00011,
      OP_INC = 5'b00100,
      OP_DEC = 5'b00101,
      OP_MUL = 5'b00110,
      OP_DIV = 5'b00111,
      OP_AND = 5'b01000,
      OP_OR  = 5'b01001,
      OP_XOR = 5'b01010,
      OP_NOT = 5'b01011,
      OP_SHL = 5'b10000,
      OP_SHR = 5'b10001,
      OP_ROL = 5'b10010,
      OP_ROR = 5'b10011
   } alu_op_e;

   typedef struct packed {
      logic carry;
      logic ovf;
      logic borrow;
   } alu_flags_t;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
   import alu8_pkg::*;
#(
   parameter int W         = 8,
   parameter bit MUL_ARRAY = 1'b1
) (
   input  logic [OP_W-1:0] op,
   input  logic [W-1:0]    a,
   input  logic [W-1:0]    b,
   input  logic            cin,
   output logic [2*W-1:0]  res,
   output alu_flags_t      fl,
   output logic            hit
);

   localparam int RW = 2 * W;

   logic [W-1:0]  addend;
   logic          cin_eff;
   logic [W:0]    sum;
   logic          signed_ovf;
   logic [RW-1:0] prod;
   logic [W-1:0]  quo;
   logic [W-1:0]  rem;
   logic [W-1:0]  part [W+1];

   // operand steering for the shared adder
   always_comb begin
      addend  = '0;
      cin_eff = 1'b0;
      case (op)
         OP_ADD: addend = b;
         OP_ADC: begin addend = b;  cin_eff = cin;  end
         OP_SUB: begin addend = ~b; cin_eff = 1'b1; end
         OP_SBB: begin addend = ~b; cin_eff = ~cin; end
         OP_INC: cin_eff = 1'b1;
         OP_DEC: addend = '1;
         default: ;
      endcase
   end

   assign sum        = {1'b0, a} + {1'b0, addend} + {{W{1'b0}}, cin_eff};
   assign signed_ovf = (a[W-1] == addend[W-1]) && (sum[W-1] != a[W-1]);

   // multiplier variant
   generate
      if (MUL_ARRAY) begin : g_mul_array
         logic [RW-1:0] pp [W];
         for (genvar i = 0; i < W; i++) begin : g_pp
            assign pp[i] = b[i] ? (RW'(a) << i) : '0;
         end
         always_comb begin
            prod = '0;
            for (int i = 0; i < W; i++) prod = prod + pp[i];
         end
         always_comb begin
            assert_mul_product_R5: assert (prod == RW'(a) * RW'(b));
         end
      end else begin : g_mul_op
         assign prod = RW'(a) * RW'(b);
      end
   endgenerate

   // restoring divider, one subtract stage per quotient bit
   assign part[0] = '0;
   generate
      for (genvar s = 0; s < W; s++) begin : g_div_stage
         logic [W:0] trial;
         logic [W:0] diff;
         assign trial             = {part[s], a[W-1-s]};
         assign diff              = trial - {1'b0, b};
         assign quo[W-1-s]        = ~diff[W];
         assign part[s+1]         = diff[W] ? trial[W-1:0] : diff[W-1:0];
      end
   endgenerate
   assign rem = part[W];

   always_comb begin
      if (b != '0) begin
         assert_div_identity_R6: assert ((RW'(quo) * RW'(b) + RW'(rem) == RW'(a)) && (rem < b));
      end
   end

   // result selection
   assign hit = (op[OP_W-1:3] == '0);

   always_comb begin
      res = '0;
      fl  = '0;
      case (op)
         OP_ADD, OP_ADC: begin
            res      = RW'(sum[W-1:0]);
            fl.carry = sum[W];
            fl.ovf   = signed_ovf;
         end
         OP_SUB, OP_SBB: begin
            res       = RW'(sum[W-1:0]);
            fl.borrow = ~sum[W];
            fl.ovf    = signed_ovf;
         end
         OP_INC: begin
            res      = RW'(sum[W-1:0]);
            fl.carry = sum[W];
         end
         OP_DEC: begin
            res       = RW'(sum[W-1:0]);
            fl.borrow = ~sum[W];
         end
         OP_MUL: res = prod;
         OP_DIV: begin
            if (b == '0) begin
               res    = '1;
               fl.ovf = 1'b1;
            end else begin
               res = {rem, quo};
            end
         end
         default: ;
      endcase
   end

   always_comb begin
      assert_carry_borrow_excl_R2: assert (!(fl.carry && fl.borrow));
      if (op == OP_INC && fl.carry) begin
         assert_inc_wrap_R4: assert (a == '1);
      end
   end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
   import alu8_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [OP_W-1:0] op,
   input  logic [W-1:0]    a,
   input  logic [W-1:0]    b,
   output logic [W-1:0]    res,
   output logic            hit
);

   always_comb begin
      hit = 1'b1;
      case (op)
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_NOT:  res = ~a;
         default: begin res = '0; hit = 1'b0; end
      endcase
   end

   always_comb begin
      if (op == OP_NOT) begin
         assert_not_complement_R8: assert ((res ^ a) == '1);
      end
   end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
   import alu8_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [OP_W-1:0] op,
   input  logic [W-1:0]    a,
   output logic [W-1:0]    res,
   output logic            carry,
   output logic            hit
);

   logic [W-1:0] left_raw;
   logic [W-1:0] right_raw;

   // bitwise move networks
   generate
      for (genvar i = 0; i < W; i++) begin : g_move
         if (i == 0) begin : g_lsb
            assign left_raw[i] = 1'b0;
         end else begin : g_lo
            assign left_raw[i] = a[i-1];
         end
         if (i == W - 1) begin : g_msb
            assign right_raw[i] = 1'b0;
         end else begin : g_hi
            assign right_raw[i] = a[i+1];
         end
      end
   endgenerate

   always_comb begin
      hit   = 1'b1;
      res   = '0;
      carry = 1'b0;
      case (op)
         OP_SHL: begin res = left_raw;                         carry = a[W-1]; end
         OP_SHR: begin res = right_raw;                        carry = a[0];   end
         OP_ROL: begin res = left_raw  | W'(a[W-1]);           carry = a[W-1]; end
         OP_ROR: begin res = right_raw | ({a[0], {(W-1){1'b0}}}); carry = a[0]; end
         default: hit = 1'b0;
      endcase
   end

   always_comb begin
      if (op == OP_ROL || op == OP_ROR) begin
         assert_rotate_ones_R9: assert ($countones(res) == $countones(a));
      end
   end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int W         = 8,
   parameter bit MUL_ARRAY = 1'b1
) (
   input  logic [W-1:0]    operand_a,
   input  logic [W-1:0]    operand_b,
   input  logic            carry_in,
   input  logic [OP_W-1:0] op_sel,
   output logic [2*W-1:0]  result,
   output logic            flag_carry,
   output logic            flag_overflow,
   output logic            flag_borrow,
   output logic            flag_zero
);

   localparam int RW = 2 * W;

   generate
      if (W < 2) begin : g_bad_width
         $error("alu8_core: operand width must be at least 2");
      end
   endgenerate

   logic [RW-1:0] arith_res;
   alu_flags_t    arith_fl;
   logic          arith_hit;
   logic [W-1:0]  logic_res;
   logic          logic_hit;
   logic [W-1:0]  shift_res;
   logic          shift_carry;
   logic          shift_hit;
   logic          any_hit;

   alu8_arith #(.W(W), .MUL_ARRAY(MUL_ARRAY)) u_arith (
      .op  (op_sel),
      .a   (operand_a),
      .b   (operand_b),
      .cin (carry_in),
      .res (arith_res),
      .fl  (arith_fl),
      .hit (arith_hit)
   );

   alu8_logic #(.W(W)) u_logic (
      .op  (op_sel),
      .a   (operand_a),
      .b   (operand_b),
      .res (logic_res),
      .hit (logic_hit)
   );

   alu8_shift #(.W(W)) u_shift (
      .op    (op_sel),
      .a     (operand_a),
      .res   (shift_res),
      .carry (shift_carry),
      .hit   (shift_hit)
   );

   assign any_hit = arith_hit | logic_hit | shift_hit;

   always_comb begin
      result        = '0;
      flag_carry    = 1'b0;
      flag_overflow = 1'b0;
      flag_borrow   = 1'b0;
      if (arith_hit) begin
         result        = arith_res;
         flag_carry    = arith_fl.carry;
         flag_overflow = arith_fl.ovf;
         flag_borrow   = arith_fl.borrow;
      end else if (logic_hit) begin
         result = RW'(logic_res);
      end else if (shift_hit) begin
         result     = RW'(shift_res);
         flag_carry = shift_carry;
      end
   end

   assign flag_zero = any_hit && (result == '0);

   always_comb begin
      assert_one_unit_R11: assert ($onehot0({arith_hit, logic_hit, shift_hit}));
      if (!any_hit) begin
         assert_invalid_quiet_R11: assert (result == '0 && !flag_carry && !flag_overflow
                                           && !flag_borrow && !flag_zero);
      end
      if (flag_zero) begin
         assert_zero_flag_R10: assert (result == '0);
      end
   end

endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NB         = 12;

   logic        clk = 1'b0;
   logic [7:0]  operand_a;
   logic [7:0]  operand_b;
   logic        carry_in;
   logic [4:0]  op_sel;
   logic [15:0] result;
   logic        flag_carry;
   logic        flag_overflow;
   logic        flag_borrow;
   logic        flag_zero;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   alu8_core u_alu8_core (
      .operand_a     (operand_a),
      .operand_b     (operand_b),
      .carry_in      (carry_in),
      .op_sel        (op_sel),
      .result        (result),
      .flag_carry    (flag_carry),
      .flag_overflow (flag_overflow),
      .flag_borrow   (flag_borrow),
      .flag_zero     (flag_zero)
   );

   function automatic int sgn8(input int x);
      return (x >= 128) ? x - 256 : x;
   endfunction

   function automatic bit sovf(input int v);
      return (v > 127) || (v < -128);
   endfunction

   function automatic int b_pick(input int i);
      case (i)
         0: return 0;    1: return 1;    2: return 2;    3: return 3;
         4: return 7;    5: return 127;  6: return 128;  7: return 129;
         8: return 170;  9: return 85;   10: return 254;
         default: return 255;
      endcase
   endfunction

   // expected behaviour derived from the requirements
   task automatic model(input int op, input int a, input int b, input int c,
                        output int r, output bit ec, output bit eo,
                        output bit eb, output bit ez, output string tag);
      int  s;
      bit  valid;
      r = 0; ec = 0; eo = 0; eb = 0; valid = 1;
      case (op)
         0, 1: begin
            s  = a + b + ((op == 1) ? c : 0);
            r  = s % 256; ec = (s > 255);
            eo = sovf(sgn8(a) + sgn8(b) + ((op == 1) ? c : 0));
            tag = "R1";
         end
         2, 3: begin
            s  = a - b - ((op == 3) ? c : 0);
            r  = (s + 256) % 256; eb = (s < 0);
            eo = sovf(sgn8(a) - sgn8(b) - ((op == 3) ? c : 0));
            tag = "R2";
         end
         4: begin r = (a + 1) % 256; ec = (a == 255); tag = "R4"; end
         5: begin r = (a + 255) % 256; eb = (a == 0); tag = "R4"; end
         6: begin r = a * b; tag = "R5"; end
         7: begin
            if (b == 0) begin r = 65535; eo = 1; tag = "R7"; end
            else begin r = (a % b) * 256 + a / b; tag = "R6"; end
         end
         8:  begin r = a & b; tag = "R8"; end
         9:  begin r = a | b; tag = "R8"; end
         10: begin r = a ^ b; tag = "R8"; end
         11: begin r = 255 - a; tag = "R8"; end
         16: begin r = (a * 2) % 256; ec = (a >= 128); tag = "R9"; end
         17: begin r = a / 2; ec = a[0]; tag = "R9"; end
         18: begin r = (a * 2) % 256 + a / 128; ec = (a >= 128); tag = "R9"; end
         19: begin r = a / 2 + (a % 2) * 128; ec = a[0]; tag = "R9"; end
         default: begin valid = 0; tag = "R11"; end
      endcase
      ez = valid && (r == 0);
      // R12: carry_in must be invisible except for codes 00001 and 00011
      if (c == 1 && op != 1 && op != 3) tag = {tag, " R12"};
   endtask

   task automatic check_vec(input int op, input int a, input int b, input int c);
      int    r;
      bit    ec, eo, eb, ez;
      string tag;
      model(op, a, b, c, r, ec, eo, eb, ez, tag);
      checks++;
      if (result != 16'(r) || flag_carry != ec || flag_borrow != eb) begin
         fails++;
         $display("FAIL %s op=%0d a=%0d b=%0d cin=%0d: result/carry/borrow %0h/%0d/%0d expected %0h/%0d/%0d",
                  tag, op, a, b, c, result, flag_carry, flag_borrow, r, ec, eb);
      end
      checks++;
      if (flag_overflow != eo) begin
         fails++;
         $display("FAIL %s op=%0d a=%0d b=%0d cin=%0d: overflow %0d expected %0d",
                  (op == 7 && b == 0) ? "R7" : "R3", op, a, b, c, flag_overflow, eo);
      end
      checks++;
      if (flag_zero != ez) begin
         fails++;
         $display("FAIL R10 op=%0d a=%0d b=%0d cin=%0d: zero %0d expected %0d",
                  op, a, b, c, flag_zero, ez);
      end
   endtask

   initial begin
      operand_a = '0; operand_b = '0; carry_in = 1'b0; op_sel = '0;
      @(negedge clk);
      // idle inputs: 0 + 0 yields zero with only the zero flag set (R1 R10)
      check_vec(0, 0, 0, 0);
      for (int op = 0; op < 32; op++) begin
         for (int a = 0; a < 256; a++) begin
            for (int bi = 0; bi < NB; bi++) begin
               @(posedge clk);
               op_sel    = 5'(op);
               operand_a = 8'(a);
               operand_b = 8'(b_pick(bi));
               carry_in  = 1'(a ^ bi);
               @(negedge clk);
               check_vec(op, a, b_pick(bi), int'(carry_in));
            end
         end
      end
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            #(CLK_PERIOD * 150000);
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule